// File: doc/BRIEF.md
# Host Expansion Window Address Decoder

This block sits on the host processor's address bus and claims accesses that land in a 4 MB expansion window. A boot-mode pin places the window either in the bottom half of the host's lower 8 MB or in the top half. The other half is left to the cartridge decoder. Inside the window the block picks one of three memories and produces the address to present to it. The three memories are a 128 KB boot ROM, a 128 KB bankable view into a 512 KB program RAM, and a 256 KB shared work RAM. Each memory repeats every 256 KB across its part of the window. Only the low address bits reach each memory, so aliases are the normal case.

The program RAM view can be moved and gated at run time. A 2-bit bank value chooses which 128 KB quarter of the RAM the host sees. A 2-bit sub-processor control value decides whether the host may reach the RAM at all. When the control value is binary 01, the sub-processor owns the RAM, and host reads and writes in the program RAM slots become open-bus accesses. Both values are loaded through a one-cycle register write port. They apply to every alias of the view at once, starting with the cycle after the write edge.

The decode itself is combinational. It is a function of the current host address, the strobes, the boot pin and the two registered configuration values. The downstream memories sample the selects and the translated address in the same cycle.

Top module: `exp_win_decode`

## Requirements
- R1: With `boot_cart`=0 the window spans 0x000000–0x3FFFFF. With `boot_cart`=1 it spans 0x400000–0x7FFFFF. An access outside the window asserts no select and no `open_bus`, and drives `xlat_addr` to 0.
- R2: In the lower 2 MB of the window, a read with address bit 17 clear asserts `sel_rom` with `xlat_addr` = address bits 16:0 (zero-extended). This repeats every 256 KB.
- R3: A write to a boot ROM slot (lower 2 MB, bit 17 clear) asserts `open_bus` and no select, so the write is discarded.
- R4: In the lower 2 MB with address bit 17 set, an access asserts `sel_pram` with `xlat_addr` = {bank, address bits 16:0}. This holds while the control value is not 2'b01.
- R5: While the control value equals 2'b01, every read or write to a program RAM slot asserts `open_bus` and not `sel_pram`. The values 2'b00, 2'b10 and 2'b11 leave the RAM visible.
- R6: In the upper 2 MB of the window, any access asserts `sel_wram` with `xlat_addr` = address bits 17:0 (zero-extended).
- R7: A cycle with `cfg_we` high loads `cfg_bank` and `cfg_ctrl` at the clock edge. Decoding before that edge uses the old values. Decoding after it uses the new values for every alias of the program RAM view.
- R8: At most one of `sel_rom`, `sel_pram`, `sel_wram` and `open_bus` is high, and exactly one is high for a strobed access inside the window. With neither strobe high, all four are low and `xlat_addr` is 0.
- R9: After reset the bank value is 0 and the control value is 2'b00, so the first quarter of program RAM is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 24 | Host byte address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| boot_cart | input | 1 | 0: window at 0x000000; 1: window at 0x400000 |
| cfg_we | input | 1 | Load bank and control values at this edge |
| cfg_bank | input | 2 | New program RAM quarter |
| cfg_ctrl | input | 2 | New sub-processor control value (01 = host locked out) |
| sel_rom | output | 1 | Boot ROM select |
| sel_pram | output | 1 | Program RAM select |
| sel_wram | output | 1 | Work RAM select |
| open_bus | output | 1 | In-window access that no memory accepts |
| xlat_addr | output | 19 | Address presented to the selected memory |

## Verification
A vector table sweeps addresses across both window placements. It covers the base slot of each memory, distant aliases (page 0x1C, 0x1F, 0x3E), a pair of addresses that differ only in bit 23, and idle cycles. A wrong mirror mask, a wrong half bit or a wrong boot-pin polarity each shows up as a different select or translated address. Directed sequences then move the bank while probing the first and the last program RAM alias, both just before and just after the write edge, which separates a delayed update from a partial one. They also step the control value through all four codes with reads, writes and a ROM read interleaved, so a lock-out that matches the wrong code, or that also blocks the ROM, is reported.

// File: rtl/exp_win_pkg.sv
package exp_win_pkg;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_ROM  = 3'd1,
    TGT_PRAM = 3'd2,
    TGT_WRAM = 3'd3,
    TGT_OPEN = 3'd4
  } tgt_e;

  localparam logic [1:0] CTRL_LOCKED = 2'b01;

endpackage

// File: rtl/exp_win_cfg.sv
module exp_win_cfg #(
  parameter int BANK_W = 2,
  parameter int CTRL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [BANK_W-1:0] bank_q,
  output logic [CTRL_W-1:0] ctrl_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      ctrl_q <= '0;
    end else if (we) begin
      bank_q <= bank_in;
      ctrl_q <= ctrl_in;
    end
  end

endmodule

// File: rtl/exp_win_region.sv
module exp_win_region
  import exp_win_pkg::*;
#(
  parameter int TOP_W = 2
) (
  input  logic [TOP_W-1:0] top_bits,
  input  logic             boot_cart,
  input  logic             upper_half,
  input  logic             page_odd,
  input  logic             rd,
  input  logic             wr,
  input  logic             locked,
  output tgt_e             tgt
);

  logic [TOP_W-1:0] win_tag;
  logic             in_win;
  logic             access;

  generate
    if (TOP_W > 1) begin : g_wide
      assign win_tag = {{(TOP_W-1){1'b0}}, boot_cart};
    end else begin : g_narrow
      assign win_tag = boot_cart;
    end
  endgenerate

  assign in_win = (top_bits == win_tag);
  assign access = rd | wr;

  always_comb begin
    tgt = TGT_NONE;
    if (access && in_win) begin
      if (upper_half) begin
        tgt = TGT_WRAM;
      end else if (!page_odd) begin
        tgt = wr ? TGT_OPEN : TGT_ROM;
      end else begin
        tgt = locked ? TGT_OPEN : TGT_PRAM;
      end
    end
  end

endmodule

// File: rtl/exp_win_xlat.sv
module exp_win_xlat
  import exp_win_pkg::*;
#(
  parameter int ROM_AW  = 17,
  parameter int WRAM_AW = 18,
  parameter int PRAM_AW = 19,
  localparam int BANK_W = PRAM_AW - ROM_AW
) (
  input  tgt_e               tgt,
  input  logic [WRAM_AW-1:0] addr_lo,
  input  logic [BANK_W-1:0]  bank,
  output logic [PRAM_AW-1:0] xlat
);

  logic [PRAM_AW-1:0] rom_a;
  logic [PRAM_AW-1:0] pram_a;
  logic [PRAM_AW-1:0] wram_a;

  assign rom_a  = {{(PRAM_AW-ROM_AW){1'b0}}, addr_lo[ROM_AW-1:0]};
  assign pram_a = {bank, addr_lo[ROM_AW-1:0]};

  generate
    if (PRAM_AW > WRAM_AW) begin : g_wram_pad
      assign wram_a = {{(PRAM_AW-WRAM_AW){1'b0}}, addr_lo};
    end else begin : g_wram_full
      assign wram_a = addr_lo;
    end
  endgenerate

  always_comb begin
    unique case (tgt)
      TGT_ROM:  xlat = rom_a;
      TGT_PRAM: xlat = pram_a;
      TGT_WRAM: xlat = wram_a;
      default:  xlat = '0;
    endcase
  end

endmodule

// File: rtl/exp_win_decode.sv
module exp_win_decode
  import exp_win_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int WIN_AW  = 22,
  parameter int ROM_AW  = 17,
  parameter int WRAM_AW = 18,
  parameter int PRAM_AW = 19,
  parameter int CTRL_W  = 2,
  localparam int BANK_W = PRAM_AW - ROM_AW,
  localparam int TOP_W  = ADDR_W - WIN_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic               boot_cart,
  input  logic               cfg_we,
  input  logic [BANK_W-1:0]  cfg_bank,
  input  logic [CTRL_W-1:0]  cfg_ctrl,
  output logic               sel_rom,
  output logic               sel_pram,
  output logic               sel_wram,
  output logic               open_bus,
  output logic [PRAM_AW-1:0] xlat_addr
);

  logic [BANK_W-1:0] bank_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              locked;
  tgt_e              tgt;
  logic              unused_mid_bits;

  exp_win_cfg #(.BANK_W(BANK_W), .CTRL_W(CTRL_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .bank_in (cfg_bank),
    .ctrl_in (cfg_ctrl),
    .bank_q  (bank_q),
    .ctrl_q  (ctrl_q)
  );

  assign locked = (ctrl_q == CTRL_LOCKED);

  exp_win_region #(.TOP_W(TOP_W)) u_region (
    .top_bits   (host_addr[ADDR_W-1:WIN_AW]),
    .boot_cart  (boot_cart),
    .upper_half (host_addr[WIN_AW-1]),
    .page_odd   (host_addr[ROM_AW]),
    .rd         (host_rd),
    .wr         (host_wr),
    .locked     (locked),
    .tgt        (tgt)
  );

  exp_win_xlat #(.ROM_AW(ROM_AW), .WRAM_AW(WRAM_AW), .PRAM_AW(PRAM_AW)) u_xlat (
    .tgt     (tgt),
    .addr_lo (host_addr[WRAM_AW-1:0]),
    .bank    (bank_q),
    .xlat    (xlat_addr)
  );

  assign sel_rom  = (tgt == TGT_ROM);
  assign sel_pram = (tgt == TGT_PRAM);
  assign sel_wram = (tgt == TGT_WRAM);
  assign open_bus = (tgt == TGT_OPEN);

  assign unused_mid_bits = ^host_addr[WIN_AW-2:WRAM_AW];

endmodule

// File: rtl/exp_win_decode_chk.sv
module exp_win_decode_chk #(
  parameter int BANK_W  = 2,
  parameter int CTRL_W  = 2,
  parameter int PRAM_AW = 19
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_rd,
  input logic               host_wr,
  input logic               cfg_we,
  input logic [BANK_W-1:0]  cfg_bank,
  input logic [CTRL_W-1:0]  cfg_ctrl,
  input logic               sel_rom,
  input logic               sel_pram,
  input logic               sel_wram,
  input logic               open_bus,
  input logic [PRAM_AW-1:0] xlat_addr,
  input logic [BANK_W-1:0]  bank_q,
  input logic [CTRL_W-1:0]  ctrl_q
);

  // R8
  single_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_rom, sel_pram, sel_wram, open_bus}));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd || host_wr) |-> !(sel_rom || sel_pram || sel_wram || open_bus));

  // R3
  rom_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rom |-> !host_wr);

  // R5
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == 2'b01) |-> !sel_pram);

  // R4
  pram_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pram |-> (xlat_addr[PRAM_AW-1:PRAM_AW-BANK_W] == bank_q));

  // R7
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (bank_q == $past(cfg_bank) && ctrl_q == $past(cfg_ctrl)));

endmodule

bind exp_win_decode exp_win_decode_chk #(
  .BANK_W(BANK_W), .CTRL_W(CTRL_W), .PRAM_AW(PRAM_AW)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_rd   (host_rd),
  .host_wr   (host_wr),
  .cfg_we    (cfg_we),
  .cfg_bank  (cfg_bank),
  .cfg_ctrl  (cfg_ctrl),
  .sel_rom   (sel_rom),
  .sel_pram  (sel_pram),
  .sel_wram  (sel_wram),
  .open_bus  (open_bus),
  .xlat_addr (xlat_addr),
  .bank_q    (bank_q),
  .ctrl_q    (ctrl_q)
);

// File: tb/exp_win_decode_test.sv
module exp_win_decode_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] host_addr = '0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic        boot_cart = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_bank = '0;
  logic [1:0]  cfg_ctrl = '0;
  logic        sel_rom, sel_pram, sel_wram, open_bus;
  logic [18:0] xlat_addr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  exp_win_decode uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .boot_cart(boot_cart), .cfg_we(cfg_we),
    .cfg_bank(cfg_bank), .cfg_ctrl(cfg_ctrl), .sel_rom(sel_rom),
    .sel_pram(sel_pram), .sel_wram(sel_wram), .open_bus(open_bus),
    .xlat_addr(xlat_addr)
  );

  // select code {rom, pram, wram, open_bus}
  localparam logic [3:0] S_NONE = 4'b0000;
  localparam logic [3:0] S_ROM  = 4'b1000;
  localparam logic [3:0] S_PRAM = 4'b0100;
  localparam logic [3:0] S_WRAM = 4'b0010;
  localparam logic [3:0] S_OPEN = 4'b0001;

  typedef struct packed {
    logic [3:0]  req;
    logic        boot;
    logic [23:0] addr;
    logic        rd;
    logic        wr;
    logic [3:0]  sel;
    logic [18:0] x;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 1'b0, 24'h000100, 1'b1, 1'b0, S_ROM,  19'h00100}, // R2 base
    '{4'd2, 1'b0, 24'h040100, 1'b1, 1'b0, S_ROM,  19'h00100}, // R2 alias
    '{4'd2, 1'b0, 24'h1C1234, 1'b1, 1'b0, S_ROM,  19'h01234}, // R2 far alias
    '{4'd4, 1'b0, 24'h020010, 1'b0, 1'b1, S_PRAM, 19'h00010}, // R4 write
    '{4'd4, 1'b0, 24'h1F0002, 1'b1, 1'b0, S_PRAM, 19'h10002}, // R4 last alias
    '{4'd3, 1'b0, 24'h000200, 1'b0, 1'b1, S_OPEN, 19'h00000}, // R3 rom write
    '{4'd6, 1'b0, 24'h200004, 1'b1, 1'b0, S_WRAM, 19'h00004}, // R6
    '{4'd6, 1'b0, 24'h3E8000, 1'b0, 1'b1, S_WRAM, 19'h28000}, // R6 alias
    '{4'd1, 1'b0, 24'h400000, 1'b1, 1'b0, S_NONE, 19'h00000}, // R1 outside
    '{4'd1, 1'b1, 24'h400000, 1'b1, 1'b0, S_ROM,  19'h00000}, // R1 moved base
    '{4'd1, 1'b1, 24'h000000, 1'b1, 1'b0, S_NONE, 19'h00000}, // R1 outside
    '{4'd1, 1'b1, 24'h622222, 1'b1, 1'b0, S_WRAM, 19'h22222}, // R1 upper
    '{4'd4, 1'b1, 24'h460000, 1'b1, 1'b0, S_PRAM, 19'h00000}, // R4 moved
    '{4'd1, 1'b0, 24'h800000, 1'b1, 1'b0, S_NONE, 19'h00000}, // R1 bit 23
    '{4'd8, 1'b0, 24'h020000, 1'b0, 1'b0, S_NONE, 19'h00000}  // R8 idle
  };

  task automatic check(input string req, input logic [3:0] exp_sel,
                       input logic [18:0] exp_x);
    logic [3:0] got;
    got = {sel_rom, sel_pram, sel_wram, open_bus};
    checks++;
    if (got !== exp_sel || xlat_addr !== exp_x) begin
      fails++;
      $display("FAIL %s addr=%h sel got=%b exp=%b xlat got=%h exp=%h",
               req, host_addr, got, exp_sel, xlat_addr, exp_x);
    end
  endtask

  task automatic apply(input logic b, input logic [23:0] a,
                       input logic r, input logic w);
    @(negedge clk);
    boot_cart = b; host_addr = a; host_rd = r; host_wr = w;
    #1;
  endtask

  task automatic write_cfg(input logic [1:0] bk, input logic [1:0] ct);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = bk; cfg_ctrl = ct;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got no finish, expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset values -> bank 0 visible, not locked
    apply(1'b0, 24'h03FFFE, 1'b1, 1'b0);
    check("R9", S_PRAM, 19'h1FFFE);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].boot, VECS[i].addr, VECS[i].rd, VECS[i].wr);
      check($sformatf("R%0d", VECS[i].req), VECS[i].sel, VECS[i].x);
    end

    // R7: old bank still in use before the edge, new one after
    @(negedge clk);
    boot_cart = 1'b0; host_addr = 24'h020000; host_rd = 1'b1; host_wr = 1'b0;
    cfg_we = 1'b1; cfg_bank = 2'd3; cfg_ctrl = 2'b00;
    #1;
    check("R7", S_PRAM, 19'h00000);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    check("R7", S_PRAM, 19'h60000);
    apply(1'b0, 24'h1E1FFE, 1'b1, 1'b0);
    check("R7", S_PRAM, 19'h61FFE);

    // R4: middle quarter
    write_cfg(2'd2, 2'b11);
    apply(1'b0, 24'h0A0004, 1'b0, 1'b1);
    check("R4", S_PRAM, 19'h40004);

    // R5: locked -> open bus on reads and writes, rom unaffected
    write_cfg(2'd2, 2'b01);
    apply(1'b0, 24'h020000, 1'b1, 1'b0);
    check("R5", S_OPEN, 19'h00000);
    apply(1'b0, 24'h1F0000, 1'b0, 1'b1);
    check("R5", S_OPEN, 19'h00000);
    apply(1'b0, 24'h010000, 1'b1, 1'b0);
    check("R5", S_ROM, 19'h10000);
    apply(1'b0, 24'h230000, 1'b1, 1'b0);
    check("R5", S_WRAM, 19'h30000);

    // R5: code 10 unlocks again
    write_cfg(2'd1, 2'b10);
    apply(1'b0, 24'h060008, 1'b1, 1'b0);
    check("R5", S_PRAM, 19'h20008);

    // R8: both strobes idle in every region
    apply(1'b0, 24'h000000, 1'b0, 1'b0);
    check("R8", S_NONE, 19'h00000);
    apply(1'b0, 24'h200000, 1'b0, 1'b0);
    check("R8", S_NONE, 19'h00000);

    // R9: reset again restores bank 0 / unlocked
    write_cfg(2'd3, 2'b01);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    apply(1'b0, 24'h022222, 1'b1, 1'b0);
    check("R9", S_PRAM, 19'h02222);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule